// File: doc/BRIEF.md
# Shared Memory Port Fetch Arbiter

This block sits at the front of a five-stage in-order pipeline: fetch, decode and register read, execute and address calculation, memory access, write back. Instruction fetch and data access share a single memory port that serves one access per cycle. Each cycle the block looks at the instruction currently in the memory stage. If that instruction is a load or a store, it gets the port, and the fetch of that cycle is given up.

On such a cycle the block holds the program counter and lets no new fetched word into the fetch/decode register. Instead it sends a no-op bubble (all zeros, marked invalid) into decode. On every other cycle the port carries the fetch of the program counter. The fetched 32-bit word is latched together with its address, and the program counter moves on by one word.

The result is that a program with no memory operations retires one instruction per cycle, and every load or store costs exactly one extra cycle. A saturating counter records the number of cycles lost to the conflict, so that this cost can be measured.

Top module: `shared_port_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is: `fetchPc` = 0, `decInstr` = 0, `decPc` = 0, `decValid` = 0, `stallCount` = 0. While `rst` is high, `pcStall`, `ifIdStall`, `bubbleInsert` and `portWe` are 0.
- R2: In a cycle with no memory-stage access, `portAddr` equals `fetchPc` and `portWe` is 0. At the next edge, `decInstr` takes `portRdata`, `decPc` takes `fetchPc`, `decValid` becomes 1, and `fetchPc` advances by 4.
- R3: When `memValid` and `memIsLoad` are both 1 (and `memIsStore` is 0), in the same cycle `portAddr` equals `memAddr`, `portWe` is 0, and `pcStall`, `ifIdStall` and `bubbleInsert` are all 1.
- R4: When `memValid` and `memIsStore` are both 1, in the same cycle `portAddr` equals `memAddr`, `portWe` is 1, `portWdata` equals `memWdata`, and all three stall outputs are 1. A store takes priority over a load flag raised at the same time.
- R5: After a stall cycle, `fetchPc` keeps its value.
- R6: After a stall cycle, `decInstr` is 0 and `decValid` is 0, while `decPc` keeps its value.
- R7: When `memValid` is 0, `memIsLoad` and `memIsStore` have no effect: the port fetches at `fetchPc`, and no stall output is raised.
- R8: `stallCount` increments by one for each stall cycle and holds at its all-ones value (2^CNT_W - 1) once it gets there.
- R9: `portWdata` is 0 in every cycle that is not a store.
- R10: Memory operations in consecutive cycles stall in consecutive cycles. The program counter does not move until the first cycle without a memory operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memValid | input | 1 | Memory stage holds a valid instruction |
| memIsLoad | input | 1 | Memory-stage instruction is a load |
| memIsStore | input | 1 | Memory-stage instruction is a store |
| memAddr | input | ADDR_W | Data address from the memory stage |
| memWdata | input | DATA_W | Store data from the memory stage |
| portRdata | input | DATA_W | Read data returned by the shared port in the same cycle |
| portAddr | output | ADDR_W | Shared port address |
| portWe | output | 1 | Shared port write enable |
| portWdata | output | DATA_W | Shared port write data |
| fetchPc | output | ADDR_W | Current program counter |
| decInstr | output | DATA_W | Fetch/decode register: instruction word |
| decPc | output | ADDR_W | Fetch/decode register: instruction address |
| decValid | output | 1 | Fetch/decode register: valid bit |
| pcStall | output | 1 | Program counter held this cycle |
| ifIdStall | output | 1 | Fetch/decode register takes no fetched word this cycle |
| bubbleInsert | output | 1 | No-op bubble enters decode at the next edge |
| stallCount | output | CNT_W | Saturating count of stall cycles |

## Verification
The embedded properties check, on every cycle, the rules that involve a single step:
- that the port address follows the memory stage whenever the data side holds the port;
- that a write never happens without a stall;
- that the program counter either holds or advances by exactly one word;
- that a bubble clears decode;
- that the counter steps or saturates.

Only the bench scenarios can show the rules that span a sequence:
- that a run of back-to-back loads and stores freezes fetch for exactly that many cycles and then resumes at the right word;
- that flags raised without `memValid` leave the fetch stream untouched;
- that the counter stops at its ceiling after a long burst;
- that a reset in mid-stream brings fetch back to address zero.

// File: rtl/shp_pkg.sv
package shp_pkg;

  // Strobes the control half sends to the datapath half each cycle.
  typedef struct packed {
    logic useData;      // memory stage owns the port this cycle
    logic writeData;    // the owning access is a write
    logic holdPc;       // program counter keeps its value
    logic holdIfId;     // fetch/decode register ignores the fetched word
    logic insertBubble; // fetch/decode register loads a no-op
  } portStrobes_t;

endpackage

// File: rtl/shp_sat_counter.sv
module shp_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      countQ <= '0;
    end else if (inc && (countQ != TOP)) begin
      countQ <= countQ + 1'b1;
    end
  end

  assign count = countQ;

  // R8: a full counter stays full.
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (countQ == TOP) |=> (countQ == TOP));

  // R8: below the top, one increment per request.
  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    (inc && (countQ != TOP)) |=> (countQ == $past(countQ) + 1'b1));

  // R8: with no request the count stays the same.
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc) |=> $stable(countQ));

endmodule

// File: rtl/shp_ctl.sv
module shp_ctl
  import shp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             memValid,
  input  logic             memIsLoad,
  input  logic             memIsStore,
  output portStrobes_t     strobes,
  output logic [CNT_W-1:0] stallCount
);

  logic dataNeedsPort;
  logic dataIsWrite;

  // The older instruction in the memory stage always wins the port.
  assign dataNeedsPort = memValid && (memIsLoad || memIsStore) && !rst;
  assign dataIsWrite   = dataNeedsPort && memIsStore;

  always_comb begin
    strobes              = '0;
    strobes.useData      = dataNeedsPort;
    strobes.writeData    = dataIsWrite;
    strobes.holdPc       = dataNeedsPort;
    strobes.holdIfId     = dataNeedsPort;
    strobes.insertBubble = dataNeedsPort;
  end

  shp_sat_counter #(.W(CNT_W)) u_stallCnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (strobes.holdPc),
    .count (stallCount)
  );

  // R7: without a valid memory-stage instruction nothing is stalled.
  a_r7_idle_no_stall: assert property (@(posedge clk) disable iff (rst)
    (!memValid) |-> (!strobes.holdPc && !strobes.useData));

  // R1: the counter reads zero on the first cycle after reset.
  a_r1_count_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stallCount == '0));

  // R3: a stall always comes with a bubble and a fetch/decode hold.
  a_r3_strobes_agree: assert property (@(posedge clk) disable iff (rst)
    strobes.holdPc |-> (strobes.holdIfId && strobes.insertBubble));

endmodule

// File: rtl/shp_datapath.sv
module shp_datapath
  import shp_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter int               DATA_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  portStrobes_t      strobes,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] portRdata,
  output logic [ADDR_W-1:0] portAddr,
  output logic              portWe,
  output logic [DATA_W-1:0] portWdata,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [DATA_W-1:0] decInstr,
  output logic [ADDR_W-1:0] decPc,
  output logic              decValid
);

  // A fetch is always one whole instruction word.
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(DATA_W / 8);

  logic [ADDR_W-1:0] pcQ;
  logic [DATA_W-1:0] instrQ;
  logic [ADDR_W-1:0] instrPcQ;
  logic              validQ;

  // Port steering
  assign portAddr  = strobes.useData ? memAddr : pcQ;
  assign portWe    = strobes.useData && strobes.writeData;
  assign portWdata = portWe ? memWdata : '0;

  // Program counter
  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ <= RESET_PC;
    end else if (!strobes.holdPc) begin
      pcQ <= pcQ + PC_STEP;
    end
  end

  // Fetch/decode register
  always_ff @(posedge clk) begin
    if (rst) begin
      instrQ   <= '0;
      instrPcQ <= '0;
      validQ   <= 1'b0;
    end else if (strobes.insertBubble) begin
      instrQ <= '0;
      validQ <= 1'b0;
    end else if (!strobes.holdIfId) begin
      instrQ   <= portRdata;
      instrPcQ <= pcQ;
      validQ   <= 1'b1;
    end
  end

  assign fetchPc  = pcQ;
  assign decInstr = instrQ;
  assign decPc    = instrPcQ;
  assign decValid = validQ;

  // R5: a stalled cycle leaves the program counter where it was.
  a_r5_pc_hold: assert property (@(posedge clk) disable iff (rst)
    strobes.holdPc |=> (pcQ == $past(pcQ)));

  // R2: an unstalled cycle advances the program counter by one word.
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!strobes.holdPc) |=> (pcQ == $past(pcQ) + PC_STEP));

  // R6: a bubble leaves decode empty and zeroed.
  a_r6_bubble_empty: assert property (@(posedge clk) disable iff (rst)
    strobes.insertBubble |=> (!validQ && (instrQ == '0)));

  // R3: the data side's address drives the port while it owns it.
  a_r3_data_addr: assert property (@(posedge clk) disable iff (rst)
    strobes.useData |-> (portAddr == memAddr));

  // R4: a write only ever happens on a stalled cycle.
  a_r4_write_stalls: assert property (@(posedge clk) disable iff (rst)
    portWe |-> strobes.holdPc);

  // R9: write data is zero whenever nothing is written.
  a_r9_wdata_quiet: assert property (@(posedge clk) disable iff (rst)
    (!portWe) |-> (portWdata == '0));

endmodule

// File: rtl/shared_port_arbiter.sv
module shared_port_arbiter
  import shp_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter int               DATA_W   = 32,
  parameter int               CNT_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              memValid,
  input  logic              memIsLoad,
  input  logic              memIsStore,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] portRdata,
  output logic [ADDR_W-1:0] portAddr,
  output logic              portWe,
  output logic [DATA_W-1:0] portWdata,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [DATA_W-1:0] decInstr,
  output logic [ADDR_W-1:0] decPc,
  output logic              decValid,
  output logic              pcStall,
  output logic              ifIdStall,
  output logic              bubbleInsert,
  output logic [CNT_W-1:0]  stallCount
);

  portStrobes_t strobes;

  shp_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .memValid   (memValid),
    .memIsLoad  (memIsLoad),
    .memIsStore (memIsStore),
    .strobes    (strobes),
    .stallCount (stallCount)
  );

  shp_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .portRdata (portRdata),
    .portAddr  (portAddr),
    .portWe    (portWe),
    .portWdata (portWdata),
    .fetchPc   (fetchPc),
    .decInstr  (decInstr),
    .decPc     (decPc),
    .decValid  (decValid)
  );

  assign pcStall      = strobes.holdPc;
  assign ifIdStall    = strobes.holdIfId;
  assign bubbleInsert = strobes.insertBubble;

  // R1: no stall is ever shown while reset is held.
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    rst |-> (!pcStall && !ifIdStall && !bubbleInsert && !portWe));

endmodule

// File: tb/tb_shared_port_arbiter.sv
module tb_shared_port_arbiter;

  localparam int CW = 4;
  localparam logic [CW-1:0] CTOP = {CW{1'b1}};

  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic        rst = 1'b1;
  logic        memValid = 1'b0, memIsLoad = 1'b0, memIsStore = 1'b0;
  logic [31:0] memAddr = '0, memWdata = '0;
  logic [31:0] portRdata, portAddr, portWdata, fetchPc, decInstr, decPc;
  logic        portWe, decValid, pcStall, ifIdStall, bubbleInsert;
  logic [CW-1:0] stallCount;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  assign portRdata = memWord(portAddr);

  shared_port_arbiter #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .memValid(memValid), .memIsLoad(memIsLoad),
    .memIsStore(memIsStore), .memAddr(memAddr), .memWdata(memWdata),
    .portRdata(portRdata), .portAddr(portAddr), .portWe(portWe),
    .portWdata(portWdata), .fetchPc(fetchPc), .decInstr(decInstr),
    .decPc(decPc), .decValid(decValid), .pcStall(pcStall),
    .ifIdStall(ifIdStall), .bubbleInsert(bubbleInsert),
    .stallCount(stallCount)
  );

  typedef struct packed {
    logic          inRst, stall, store, valid, prevStall;
    logic [31:0]   eAddr;
    logic          eWe;
    logic [31:0]   eWdata, ePc, eInstr, eDecPc;
    logic          eDecValid;
    logic [CW-1:0] eCnt;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0, bad = 0;

  // Reference model state: what the registers hold after the next edge.
  logic [31:0]   mPc = '0, mInstr = '0, mDecPc = '0;
  logic          mValid = 1'b0, mPrev = 1'b0;
  logic [CW-1:0] mCnt = '0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic ld,
                      input logic st, input logic [31:0] a,
                      input logic [31:0] w);
    expItem_t it;
    logic s;
    @(negedge clk);
    rst = r; memValid = v; memIsLoad = ld; memIsStore = st;
    memAddr = a; memWdata = w;
    s = v && (ld || st) && !r;
    it.inRst = r; it.stall = s; it.store = s && st; it.valid = v;
    it.prevStall = mPrev;
    it.eAddr = s ? a : mPc;
    it.eWe = s && st;
    it.eWdata = (s && st) ? w : 32'h0;
    it.ePc = mPc; it.eInstr = mInstr; it.eDecPc = mDecPc;
    it.eDecValid = mValid; it.eCnt = mCnt;
    expQ.push_back(it);
    if (r) begin
      mPc = '0; mInstr = '0; mDecPc = '0; mValid = 1'b0; mCnt = '0;
      mPrev = 1'b0;
    end else if (s) begin
      mInstr = '0; mValid = 1'b0;
      if (mCnt != CTOP) mCnt = mCnt + 1'b1;
      mPrev = 1'b1;
    end else begin
      mInstr = memWord(mPc); mDecPc = mPc; mValid = 1'b1;
      mPc = mPc + 32'd4;
      mPrev = 1'b0;
    end
  endtask

  // Monitor: compares just before the rising edge.
  always begin
    expItem_t it;
    string pt, rt, dt;
    @(negedge clk);
    #3;
    while (expQ.size() > 0) begin
      it = expQ.pop_front();
      if (it.inRst)      pt = "R1";
      else if (it.store) pt = "R4";
      else if (it.stall) pt = "R3";
      else if (it.valid) pt = "R7";
      else               pt = "R2";
      if (it.inRst)                        rt = "R1";
      else if (it.prevStall && it.stall)   rt = "R10";
      else if (it.prevStall)               rt = "R5";
      else                                 rt = "R2";
      dt = it.prevStall ? "R6" : "R2";
      chk(pt, "portAddr", portAddr, it.eAddr);
      chk(pt, "portWe", {31'b0, portWe}, {31'b0, it.eWe});
      chk(it.store ? "R4" : "R9", "portWdata", portWdata, it.eWdata);
      chk(pt, "pcStall", {31'b0, pcStall}, {31'b0, it.stall});
      chk(pt, "ifIdStall", {31'b0, ifIdStall}, {31'b0, it.stall});
      chk(pt, "bubbleInsert", {31'b0, bubbleInsert}, {31'b0, it.stall});
      chk(rt, "fetchPc", fetchPc, it.ePc);
      chk(dt, "decInstr", decInstr, it.eInstr);
      chk(dt, "decPc", decPc, it.eDecPc);
      chk(dt, "decValid", {31'b0, decValid}, {31'b0, it.eDecValid});
      chk("R8", "stallCount", {{(32-CW){1'b0}}, stallCount},
          {{(32-CW){1'b0}}, it.eCnt});
    end
  end

  bit finished = 1'b0;

  initial begin
    // R1: reset held for a few cycles with noise on the flags
    step(1, 0, 0, 0, 32'h0, 32'h0);
    step(1, 1, 1, 0, 32'h100, 32'h0);
    step(1, 1, 0, 1, 32'h104, 32'hDEAD_BEEF);
    // R2: plain fetch stream
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 32'h0, 32'h0);
    // R3: one load
    step(0, 1, 1, 0, 32'h0000_2000, 32'h1111_1111);
    step(0, 0, 0, 0, 32'h0, 32'h0);
    // R4: one store
    step(0, 1, 0, 1, 32'h0000_3004, 32'hCAFE_F00D);
    step(0, 0, 0, 0, 32'h0, 32'h0);
    // R4: load and store flags together behave as a store
    step(0, 1, 1, 1, 32'h0000_3008, 32'h0BAD_CAFE);
    step(0, 0, 0, 0, 32'h0, 32'h0);
    // R10: back-to-back memory operations
    step(0, 1, 1, 0, 32'h0000_4000, 32'h0);
    step(0, 1, 0, 1, 32'h0000_4004, 32'h5555_AAAA);
    step(0, 1, 1, 0, 32'h0000_4008, 32'h0);
    step(0, 0, 0, 0, 32'h0, 32'h0);
    step(0, 0, 0, 0, 32'h0, 32'h0);
    // R7: flags without memValid, and memValid with neither flag
    step(0, 0, 1, 0, 32'h0000_5000, 32'h0);
    step(0, 0, 0, 1, 32'h0000_5004, 32'h7777_7777);
    step(0, 1, 0, 0, 32'h0000_5008, 32'h0);
    step(0, 0, 0, 0, 32'h0, 32'h0);
    // R8: long burst drives the counter into saturation
    for (int i = 0; i < 20; i++)
      step(0, 1, i[0], !i[0], 32'h0000_6000 + 32'(i * 4), 32'(i));
    step(0, 0, 0, 0, 32'h0, 32'h0);
    step(0, 1, 1, 0, 32'h0000_7000, 32'h0);
    step(0, 0, 0, 0, 32'h0, 32'h0);
    // R1: reset in mid-stream returns fetch to zero
    step(1, 1, 1, 0, 32'h0000_8000, 32'h0);
    step(0, 0, 0, 0, 32'h0, 32'h0);
    step(0, 0, 0, 0, 32'h0, 32'h0);
    step(0, 1, 0, 1, 32'h0000_9000, 32'h1234_5678);
    step(0, 0, 0, 0, 32'h0, 32'h0);
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule